// File: doc/BRIEF.md
# Reset-Gated Wide Bus Selector

This block picks one of N wide source buses and delivers it, registered, on a single output bus, without building a multiplexer tree. Each source bus has its own capture register. On every clock edge only the register belonging to the selected source loads its input. All the other registers are driven to zero by a synchronous clear. Because at most one register can hold a nonzero value, a plain bitwise OR of all register outputs yields the selected bus. An optional register after the OR can be switched on by a parameter to shorten the combinational path.

The block is meant for wide datapath steering where flip-flops are plentiful and logic depth is the limit. The cost is one register per source bit, and in return each output bit needs only a wide OR. The defaults are 16 sources of 16 bits each. A select value that names no source clears every register, so the output reads zero.

Top module: `rgm_wide_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears, and `dout` reads zero from the next edge on.
- R2: With `OUT_REG`=1 (the default), the value of source `sel` present at clock edge k appears on `dout` after edge k+1. Source i occupies bits `[i*W +: W]` of `src_flat`.
- R3: A `sel` value of N or more clears every source register, and `dout` reads zero after the same latency as R2.
- R4: After a select change, the first new output holds only the newly chosen source, with no bits left over from the previous one. At most one source register is nonzero at any time.
- R5: A change on any source other than the selected one has no effect on `dout`.
- R6: All W bit positions pass through unchanged, including all-ones, all-zeros and walking-one patterns.
- R7: The output register after the OR is present when `OUT_REG`=1, giving a latency of two edges. When `OUT_REG`=0 it is absent and the latency is one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | SEL_W | Index of the chosen source; N or more selects nothing |
| src_flat | input | N*W | All sources packed side by side, source i at bits [i*W +: W] |
| dout | output | W | Selected source, registered |

## Verification
The checker assumes that `sel` and `src_flat` are settled before each rising edge and that `rst_n` is held low for at least one edge before normal use. Its history-based checks wait until enough edges have passed since reset to cover the latency.

The bench drives every input on the falling edge, so these assumptions always hold. It asserts reset for several edges at the start. Out-of-range select values are applied on purpose, because R3 defines how the block behaves for them.

// File: rtl/rgm_pkg.sv
package rgm_pkg;

   // Number of clock edges from a captured source to the output port.
   function automatic int unsigned rgm_latency(input int unsigned out_reg);
      return 1 + out_reg;
   endfunction

   // Nonzero-lane detector shared by the checker.
   function automatic logic rgm_any(input logic [63:0] v);
      return |v;
   endfunction

endpackage

// File: rtl/rgm_clear_decode.sv
module rgm_clear_decode #(
   parameter int unsigned N     = 16,
   parameter int unsigned SEL_W = 5
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     clr
);
   logic in_range;

   always_comb begin
      in_range = (32'(sel) < 32'(N));
   end

   for (genvar i = 0; i < N; i++) begin : g_dec
      always_comb begin
         clr[i] = !(in_range && (32'(sel) == 32'(i)));
      end
   end
endmodule

// File: rtl/rgm_lane.sv
module rgm_lane #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end
endmodule

// File: rtl/rgm_or_fold.sv
module rgm_or_fold #(
   parameter int unsigned N       = 16,
   parameter int unsigned W       = 16,
   parameter int unsigned OUT_REG = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N*W-1:0] lanes,
   output logic [W-1:0]   or_comb,
   output logic [W-1:0]   y
);
   always_comb begin
      or_comb = '0;
      for (int i = 0; i < N; i++) begin
         or_comb = or_comb | lanes[i*W +: W];
      end
   end

   if (OUT_REG != 0) begin : g_reg
      logic [W-1:0] y_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            y_q <= '0;
         end else begin
            y_q <= or_comb;
         end
      end
      assign y = y_q;
   end else begin : g_comb
      assign y = or_comb;
   end
endmodule

// File: rtl/rgm_wide_mux.sv
module rgm_wide_mux #(
   parameter int unsigned N       = 16,
   parameter int unsigned W       = 16,
   parameter int unsigned SEL_W   = 5,
   parameter int unsigned OUT_REG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic [N*W-1:0]   src_flat,
   output logic [W-1:0]     dout
);
   localparam int unsigned IDX_W = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("rgm_wide_mux: N must be at least 2");
   end
   if (W < 1 || W > 64) begin : g_bad_w
      $error("rgm_wide_mux: W must be 1..64");
   end
   if (SEL_W < IDX_W) begin : g_bad_sel
      $error("rgm_wide_mux: SEL_W too narrow for N");
   end
   if (OUT_REG > 1) begin : g_bad_or
      $error("rgm_wide_mux: OUT_REG must be 0 or 1");
   end

   logic [N-1:0]   clr;
   logic [N*W-1:0] lane_q;
   logic [W-1:0]   or_comb;

   rgm_clear_decode #(.N(N), .SEL_W(SEL_W)) dec_i (
      .sel (sel),
      .clr (clr)
   );

   for (genvar i = 0; i < N; i++) begin : g_lane
      rgm_lane #(.W(W)) lane_i (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr[i]),
         .d     (src_flat[i*W +: W]),
         .q     (lane_q[i*W +: W])
      );
   end

   rgm_or_fold #(.N(N), .W(W), .OUT_REG(OUT_REG)) fold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lanes   (lane_q),
      .or_comb (or_comb),
      .y       (dout)
   );
endmodule

// File: rtl/rgm_wide_mux_chk.sv
module rgm_wide_mux_chk #(
   parameter int unsigned N       = 16,
   parameter int unsigned W       = 16,
   parameter int unsigned SEL_W   = 5,
   parameter int unsigned OUT_REG = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] sel,
   input logic [N*W-1:0]   lane_q,
   input logic [W-1:0]     or_comb,
   input logic [W-1:0]     dout
);
   import rgm_pkg::*;

   logic [1:0]   since_rst;
   logic [N-1:0] live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_live
      always_comb begin
         live[i] = rgm_any(64'(lane_q[i*W +: W]));
      end
      AST_LANE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst != 2'd0 && live[i]) |-> (32'($past(sel)) == 32'(i))); // R4
   end

   AST_ONE_LANE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(live)); // R4

   AST_OOR_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && 32'($past(sel)) >= 32'(N)) |-> (live == '0)); // R3

   if (OUT_REG != 0) begin : g_chk_reg
      AST_OUT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst != 2'd0) |-> (dout == $past(or_comb))); // R7
   end else begin : g_chk_comb
      AST_OUT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
         dout == or_comb); // R7
   end

   AST_RESET_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd1 && rgm_latency(OUT_REG) == 2) |-> (dout == '0)); // R1
endmodule

bind rgm_wide_mux rgm_wide_mux_chk #(
   .N(N), .W(W), .SEL_W(SEL_W), .OUT_REG(OUT_REG)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (sel),
   .lane_q  (lane_q),
   .or_comb (or_comb),
   .dout    (dout)
);

// File: tb/rgm_wide_mux_tb_top.sv
`timescale 1ns/1ps
module rgm_wide_mux_tb_top;
   localparam int unsigned N = 16;
   localparam int unsigned W = 16;
   localparam int unsigned SEL_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [SEL_W-1:0] sel = '0;
   logic [N*W-1:0]   src_flat = '0;
   logic [W-1:0]     dout;
   logic [W-1:0]     exp0 = '0;
   logic [W-1:0]     exp1 = '0;
   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   rgm_wide_mux #(.N(N), .W(W), .SEL_W(SEL_W), .OUT_REG(1)) dut_i (
      .clk (clk), .rst_n (rst_n), .sel (sel), .src_flat (src_flat), .dout (dout)
   );

   // Plain case-style reference mux, delayed by two edges.
   function automatic logic [W-1:0] ref_pick(input logic [SEL_W-1:0] s,
                                             input logic [N*W-1:0] f);
      logic [W-1:0] r;
      r = '0;
      for (int i = 0; i < N; i++) begin
         if (32'(s) == 32'(i)) r = f[i*W +: W];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      exp0 <= rst_n ? ref_pick(sel, src_flat) : '0;
      exp1 <= rst_n ? exp0 : '0;
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: dout=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_src(input int i, input logic [W-1:0] v);
      src_flat[i*W +: W] = v;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) set_src(i, 16'hFFFF);
      sel = 5'd2;
      repeat (3) step();
      chk("R1 reset", dout, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_sweep();
      for (int i = 0; i < N; i++) set_src(i, W'(16'h1000 * i + 16'h0101 * i + 16'h5));
      for (int s = 0; s < N; s++) begin
         sel = SEL_W'(s);
         step(); step();
         chk("R2 sweep", dout, exp1);
         chk("R2 sweep direct", dout, W'(16'h1000 * s + 16'h0101 * s + 16'h5));
      end
   endtask

   task automatic t_latency();
      sel = 5'd7;
      set_src(7, 16'hAAAA);
      step(); step();
      set_src(7, 16'h5555);
      step();
      chk("R7 one edge still old", dout, 16'hAAAA);
      step();
      chk("R7 two edges new", dout, 16'h5555);
   endtask

   task automatic t_switch();
      for (int i = 0; i < N; i++) set_src(i, W'(1) << i);
      sel = 5'd0;
      step(); step();
      for (int k = 1; k < 24; k++) begin
         sel = SEL_W'((k * 5) % N);
         step();
         chk("R4 switch model", dout, exp1);
      end
      sel = 5'd3;
      step();
      sel = 5'd12;
      step();
      chk("R4 first after switch", dout, 16'h0008);
      step();
      chk("R4 no blend", dout, 16'h1000);
   endtask

   task automatic t_oor();
      for (int i = 0; i < N; i++) set_src(i, 16'hFFFF);
      for (int v = N; v < 32; v += 5) begin
         sel = SEL_W'(v);
         step(); step();
         chk("R3 out of range", dout, '0);
      end
      sel = 5'd31;
      step(); step();
      chk("R3 max code", dout, '0);
   endtask

   task automatic t_unselected();
      sel = 5'd9;
      set_src(9, 16'hC3A5);
      step(); step();
      for (int k = 0; k < 20; k++) begin
         for (int i = 0; i < N; i++) if (i != 9) set_src(i, W'($urandom));
         step();
         chk("R5 unselected change", dout, 16'hC3A5);
      end
   endtask

   task automatic t_bits();
      sel = 5'd15;
      set_src(15, 16'hFFFF); step(); step();
      chk("R6 all ones", dout, 16'hFFFF);
      set_src(15, 16'h0000); step(); step();
      chk("R6 all zeros", dout, 16'h0000);
      for (int b = 0; b < W; b++) begin
         set_src(15, W'(1) << b); step(); step();
         chk("R6 walking one", dout, W'(1) << b);
      end
   endtask

   task automatic t_rereset();
      sel = 5'd1; set_src(1, 16'h1234); step(); step();
      rst_n = 1'b0; step();
      rst_n = 1'b1; sel = 5'd20; step();
      chk("R1 re-reset clears", dout, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: dout=%h expected=finish", dout);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step();
      t_reset();
      t_sweep();
      t_latency();
      t_switch();
      t_oor();
      t_unselected();
      t_bits();
      t_rereset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule